// File: doc/BRIEF.md
# Management Frame Classifier

This block sits on the receive side of a seven-port switch. It watches the byte streams of all data ports but acts only on the port currently chosen as the management port. On that port it holds back the first sixteen bytes of every frame. These bytes are the destination address, the source address and a four-byte tag. From them it decides where the whole frame goes. A frame addressed to the switch's own MAC address and carrying the management tag type goes to the management output. Any other frame on that port leaves unchanged on the pass-through output.

Only one management frame is handled at a time. Once a frame is accepted, the block stays busy until the response builder pulses response-done. A management frame that arrives while the block is busy is discarded whole, and a drop strobe is raised. Ordinary traffic on the management port keeps flowing while the block is busy. The feature enable is taken from a strap input while reset is held. The management port can be moved later with a port write, and the new port takes effect only between frames. Frames on the selected port are assumed to be separated by at least sixteen idle cycles, as preamble and inter-frame gap give on a real link.

Top module: `mgmt_frame_classifier`

## Requirements
- R1: While reset is asserted and afterwards until the first decision, no byte appears on either output and the drop strobe is low. Port 7 is the management port after reset.
- R2: The enable is sampled from `strapEn` during reset only. With it low, every frame on the management port goes to the pass-through output, and a later change of `strapEn` has no effect.
- R3: A frame qualifies only if all of these hold: bytes 0..5 equal the MAC parameter (byte 0 is the most significant byte, default 00-10-A1-FF-FF-FF), byte 12 is 0x98, byte 13 is 0x00, and bit 4 of byte 14 (the CFI bit) is 0. Bits 7:5 and 3:0 of byte 14 and all of byte 15 do not matter.
- R4: When the block is idle, a qualifying frame appears on the management output whole and in order, with start marked on the first byte and end on the last. None of it appears on the pass-through output.
- R5: A non-qualifying frame on the management port appears unchanged on the pass-through output, with its start and end markers. This includes any frame shorter than 16 bytes.
- R6: A qualifying frame that arrives while the block is busy produces no byte on either output. The drop strobe is then high for exactly one cycle.
- R7: A response-done pulse clears the busy condition, and the next qualifying frame is accepted.
- R8: A non-qualifying frame received while the block is busy still passes through unchanged.
- R9: Frames on a port other than the management port produce nothing on any output.
- R10: A port write with a value from 1 to 7 selects that port. The change takes effect only when no frame is in progress on the current port. Values 0 and above 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| strapEn | input | 1 | Feature enable, sampled during reset |
| cfgPortWr | input | 1 | Port-select write strobe |
| cfgPortNum | input | 3 | Port number written (1..7) |
| respDone | input | 1 | Pulse from the response builder: the response has been sent |
| rxData | input | 56 | Received byte of each port, port p at bits 8p-1:8p-8 |
| rxValid | input | 7 | Byte valid per port |
| rxSof | input | 7 | First byte of frame per port |
| rxEof | input | 7 | Last byte of frame per port |
| mgmtData | output | 8 | Management stream byte |
| mgmtValid | output | 1 | Management byte valid |
| mgmtSof | output | 1 | Management first byte |
| mgmtEof | output | 1 | Management last byte |
| passData | output | 8 | Pass-through stream byte |
| passValid | output | 1 | Pass-through byte valid |
| passSof | output | 1 | Pass-through first byte |
| passEof | output | 1 | Pass-through last byte |
| dropPulse | output | 1 | One-cycle strobe: a management frame was discarded while busy |

## Verification
The bench builds the block with its defaults: seven ports, a 16-byte header and the default MAC. With only seven ports, every pairing of selected port and source port can be swept in full. The bench also corrupts each of the eight checked header bytes and the CFI bit one at a time. Frame lengths run across every value from 1 to 15 and across a range above the header length, so short frames, the exactly-16-byte frame and frames with an idle gap inside all occur.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int HDR_LEN  = 16;
  localparam logic [7:0] TAG_TYPE_HI = 8'h98;
  localparam logic [7:0] TAG_TYPE_LO = 8'h00;

  typedef enum logic [1:0] {
    ROUTE_PASS = 2'd0,
    ROUTE_MGMT = 2'd1,
    ROUTE_DROP = 2'd2
  } route_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;    // store the selected byte
    logic popEn;   // release the head byte
    logic toMgmt;  // released byte goes to management output
    logic toPass;  // released byte goes to pass-through output
  } strobe_t;
endpackage

// File: rtl/mfc_datapath.sv
module mfc_datapath
  import mfc_pkg::*;
#(
  parameter int          NPORTS = 7,
  parameter logic [47:0] MAC    = 48'h0010A1FFFFFF,
  parameter int          PW     = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NPORTS*8-1:0] rxData,
  input  logic [NPORTS-1:0]   rxValid,
  input  logic [NPORTS-1:0]   rxSof,
  input  logic [NPORTS-1:0]   rxEof,
  input  logic [PW-1:0]       curPort,
  input  strobe_t             strb,
  output logic                selValid,
  output logic                selSof,
  output logic                selEof,
  output logic                hdrMatch,
  output logic                headEof,
  output logic                notEmpty,
  output logic [7:0]          mgmtData,
  output logic                mgmtValid,
  output logic                mgmtSof,
  output logic                mgmtEof,
  output logic [7:0]          passData,
  output logic                passValid,
  output logic                passSof,
  output logic                passEof
);
  localparam int DEPTH = 2 * HDR_LEN;
  localparam int AW    = $clog2(DEPTH);
  localparam int SH    = HDR_LEN - 1;

  logic [7:0]  selData;
  logic [7:0]  hdrSh [SH];
  logic [9:0]  fifoMem [DEPTH];
  logic [AW:0] wrPtr, rdPtr;
  logic [9:0]  head;

  // select the management port's stream
  always_comb begin
    selData  = '0;
    selValid = 1'b0;
    selSof   = 1'b0;
    selEof   = 1'b0;
    for (int p = 0; p < NPORTS; p++) begin
      if (int'(curPort) == p + 1) begin
        selData  = rxData[p*8 +: 8];
        selValid = rxValid[p];
        selSof   = rxSof[p];
        selEof   = rxEof[p];
      end
    end
  end

  // last SH stored bytes: at decision time byte k sits at index SH-1-k
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SH; i++) hdrSh[i] <= '0;
    end else if (strb.wrEn) begin
      hdrSh[0] <= selData;
      for (int i = 1; i < SH; i++) hdrSh[i] <= hdrSh[i-1];
    end
  end

  always_comb begin
    hdrMatch = 1'b1;
    for (int k = 0; k < 6; k++) begin
      if (hdrSh[SH-1-k] != MAC[47-8*k -: 8]) hdrMatch = 1'b0;
    end
    if (hdrSh[SH-13] != TAG_TYPE_HI) hdrMatch = 1'b0;
    if (hdrSh[SH-14] != TAG_TYPE_LO) hdrMatch = 1'b0;
    if (hdrSh[SH-15][4])             hdrMatch = 1'b0;
  end

  // frame store: {sof, eof, data}
  always_ff @(posedge clk) begin
    if (strb.wrEn) fifoMem[wrPtr[AW-1:0]] <= {selSof, selEof, selData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.wrEn)  wrPtr <= wrPtr + 1'b1;
      if (strb.popEn) rdPtr <= rdPtr + 1'b1;
    end
  end

  assign head     = fifoMem[rdPtr[AW-1:0]];
  assign notEmpty = (wrPtr != rdPtr);
  assign headEof  = head[8];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mgmtValid <= 1'b0;
      passValid <= 1'b0;
      {mgmtSof, mgmtEof, mgmtData} <= '0;
      {passSof, passEof, passData} <= '0;
    end else begin
      mgmtValid <= strb.popEn && strb.toMgmt;
      passValid <= strb.popEn && strb.toPass;
      {mgmtSof, mgmtEof, mgmtData} <= head;
      {passSof, passEof, passData} <= head;
    end
  end
endmodule

// File: rtl/mfc_ctrl.sv
module mfc_ctrl
  import mfc_pkg::*;
#(
  parameter int NPORTS = 7,
  parameter int PW     = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          strapEn,
  input  logic          cfgPortWr,
  input  logic [PW-1:0] cfgPortNum,
  input  logic          respDone,
  input  logic          selValid,
  input  logic          selSof,
  input  logic          selEof,
  input  logic          hdrMatch,
  input  logic          headEof,
  input  logic          notEmpty,
  output strobe_t       strb,
  output logic [PW-1:0] curPort,
  output logic          dropPulse,
  output logic          busy,
  output logic          inFrame
);
  localparam int CW = $clog2(HDR_LEN);
  localparam logic [CW-1:0] LAST = CW'(HDR_LEN - 1);

  logic          enLatch;
  logic [CW-1:0] cnt, idxNow;
  logic          decided, decValid;
  route_e        route, newRoute;
  logic          accept, decideNow, qualify;
  logic [PW-1:0] pendPort;
  logic          pendValid;
  logic          portOk;

  assign accept    = selValid && (selSof || inFrame);
  assign idxNow    = selSof ? '0 : cnt;
  assign decideNow = accept && (selSof || !decided) && ((idxNow == LAST) || selEof);
  assign qualify   = enLatch && hdrMatch && (idxNow == LAST);
  assign newRoute  = qualify ? (busy ? ROUTE_DROP : ROUTE_MGMT) : ROUTE_PASS;
  assign portOk    = (cfgPortNum != '0) && (int'(cfgPortNum) <= NPORTS);

  assign strb.wrEn   = accept;
  assign strb.popEn  = decValid && notEmpty;
  assign strb.toMgmt = (route == ROUTE_MGMT);
  assign strb.toPass = (route == ROUTE_PASS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enLatch   <= strapEn;
      curPort   <= PW'(NPORTS);
      pendPort  <= '0;
      pendValid <= 1'b0;
      inFrame   <= 1'b0;
      cnt       <= '0;
      decided   <= 1'b0;
      decValid  <= 1'b0;
      route     <= ROUTE_PASS;
      busy      <= 1'b0;
      dropPulse <= 1'b0;
    end else begin
      if (accept) begin
        inFrame <= !selEof;
        cnt     <= (idxNow == LAST) ? idxNow : idxNow + 1'b1;
        decided <= (decided && !selSof) || decideNow;
      end

      if (decideNow) begin
        decValid <= 1'b1;
        route    <= newRoute;
      end else if (strb.popEn && headEof) begin
        decValid <= 1'b0;
      end

      if (decideNow && newRoute == ROUTE_MGMT) busy <= 1'b1;
      else if (respDone)                       busy <= 1'b0;

      dropPulse <= decideNow && (newRoute == ROUTE_DROP);

      // port change only between frames; a fresh write overrides
      if (pendValid && !inFrame && !accept) begin
        curPort   <= pendPort;
        pendValid <= 1'b0;
      end
      if (cfgPortWr && portOk) begin
        pendPort  <= cfgPortNum;
        pendValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mgmt_frame_classifier.sv
module mgmt_frame_classifier
  import mfc_pkg::*;
#(
  parameter int          NPORTS = 7,
  parameter logic [47:0] MAC    = 48'h0010A1FFFFFF,
  parameter int          PW     = $clog2(NPORTS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                strapEn,
  input  logic                cfgPortWr,
  input  logic [PW-1:0]       cfgPortNum,
  input  logic                respDone,
  input  logic [NPORTS*8-1:0] rxData,
  input  logic [NPORTS-1:0]   rxValid,
  input  logic [NPORTS-1:0]   rxSof,
  input  logic [NPORTS-1:0]   rxEof,
  output logic [7:0]          mgmtData,
  output logic                mgmtValid,
  output logic                mgmtSof,
  output logic                mgmtEof,
  output logic [7:0]          passData,
  output logic                passValid,
  output logic                passSof,
  output logic                passEof,
  output logic                dropPulse
);
  strobe_t       strb;
  logic [PW-1:0] curPort;
  logic          selValid, selSof, selEof;
  logic          hdrMatch, headEof, notEmpty;
  logic          busy, inFrame;

  mfc_ctrl #(.NPORTS(NPORTS), .PW(PW)) u_ctrl (
    .clk(clk), .rstN(rstN), .strapEn(strapEn),
    .cfgPortWr(cfgPortWr), .cfgPortNum(cfgPortNum), .respDone(respDone),
    .selValid(selValid), .selSof(selSof), .selEof(selEof),
    .hdrMatch(hdrMatch), .headEof(headEof), .notEmpty(notEmpty),
    .strb(strb), .curPort(curPort), .dropPulse(dropPulse),
    .busy(busy), .inFrame(inFrame)
  );

  mfc_datapath #(.NPORTS(NPORTS), .MAC(MAC), .PW(PW)) u_dp (
    .clk(clk), .rstN(rstN),
    .rxData(rxData), .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof),
    .curPort(curPort), .strb(strb),
    .selValid(selValid), .selSof(selSof), .selEof(selEof),
    .hdrMatch(hdrMatch), .headEof(headEof), .notEmpty(notEmpty),
    .mgmtData(mgmtData), .mgmtValid(mgmtValid), .mgmtSof(mgmtSof), .mgmtEof(mgmtEof),
    .passData(passData), .passValid(passValid), .passSof(passSof), .passEof(passEof)
  );
endmodule

// File: rtl/mfc_checker.sv
module mfc_checker #(
  parameter int NPORTS = 7,
  parameter int PW     = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          mgmtValid,
  input logic          passValid,
  input logic          dropPulse,
  input logic          busy,
  input logic          inFrame,
  input logic [PW-1:0] curPort
);
  // R4
  excl_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(mgmtValid && passValid));

  // R6
  drop_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    dropPulse |=> !dropPulse);

  // R6
  drop_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    dropPulse |-> $past(busy));

  // R10
  port_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    inFrame |=> $stable(curPort));

  // R10
  port_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curPort != '0) && (int'(curPort) <= NPORTS));
endmodule

bind mgmt_frame_classifier mfc_checker #(.NPORTS(NPORTS), .PW(PW)) u_chk (
  .clk(clk), .rstN(rstN), .mgmtValid(mgmtValid), .passValid(passValid),
  .dropPulse(dropPulse), .busy(busy), .inFrame(inFrame), .curPort(curPort)
);

// File: tb/mgmt_frame_classifier_test.sv
module mgmt_frame_classifier_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPORTS = 7;
  localparam logic [47:0] MAC = 48'h0010A1FFFFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapEn = 1'b1;
  logic cfgPortWr = 1'b0;
  logic [2:0] cfgPortNum = '0;
  logic respDone = 1'b0;
  logic [NPORTS*8-1:0] rxData = '0;
  logic [NPORTS-1:0] rxValid = '0, rxSof = '0, rxEof = '0;
  logic [7:0] mgmtData, passData;
  logic mgmtValid, mgmtSof, mgmtEof, passValid, passSof, passEof, dropPulse;

  int nChecks = 0;
  int nFails  = 0;
  int dropCnt = 0;
  logic [9:0] expM[$], expP[$], gotM[$], gotP[$];
  logic [7:0] frm [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_frame_classifier uut (
    .clk(clk), .rstN(rstN), .strapEn(strapEn), .cfgPortWr(cfgPortWr),
    .cfgPortNum(cfgPortNum), .respDone(respDone), .rxData(rxData),
    .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof),
    .mgmtData(mgmtData), .mgmtValid(mgmtValid), .mgmtSof(mgmtSof), .mgmtEof(mgmtEof),
    .passData(passData), .passValid(passValid), .passSof(passSof), .passEof(passEof),
    .dropPulse(dropPulse)
  );

  always @(negedge clk) begin
    if (mgmtValid) gotM.push_back({mgmtSof, mgmtEof, mgmtData});
    if (passValid) gotP.push_back({passSof, passEof, passData});
    if (dropPulse) dropCnt++;
  end

  task automatic report(input bit ok, input string req, input string what,
                        input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic strap);
    rstN = 1'b0;
    strapEn = strap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    gotM.delete(); gotP.delete(); expM.delete(); expP.delete();
    dropCnt = 0;
  endtask

  task automatic pulseDone();
    @(negedge clk) respDone = 1'b1;
    @(negedge clk) respDone = 1'b0;
  endtask

  task automatic writePort(input int num);
    @(negedge clk) begin cfgPortWr = 1'b1; cfgPortNum = 3'(num); end
    @(negedge clk) cfgPortWr = 1'b0;
  endtask

  // kind: 0 qualifying, 1..6 corrupt DA byte kind-1, 7/8 corrupt type byte,
  // 9 CFI set, 10 unrelated frame. dest: 0 none, 1 mgmt, 2 pass
  task automatic sendFrame(input int port, input int len, input int kind,
                           input int seed, input int dest,
                           input int wrAt, input int wrPort);
    for (int i = 0; i < len; i++) frm[i] = 8'((i * 7 + seed) & 255);
    for (int k = 0; k < 6; k++) frm[k] = MAC[47-8*k -: 8];
    for (int k = 6; k < 12; k++) frm[k] = 8'(8'h20 + k);
    frm[12] = 8'h98; frm[13] = 8'h00;
    frm[14] = 8'({seed[2:0], 1'b0, seed[3:0]});
    frm[15] = 8'(seed);
    if (kind >= 1 && kind <= 6) frm[kind-1] = frm[kind-1] ^ 8'h01;
    if (kind == 7)  frm[12] = 8'h99;
    if (kind == 8)  frm[13] = 8'h01;
    if (kind == 9)  frm[14] = frm[14] | 8'h10;
    if (kind == 10) begin frm[0] = 8'h02; frm[12] = 8'h08; end
    for (int i = 0; i < len; i++) begin
      if (dest == 1) expM.push_back({i == 0, i == len - 1, frm[i]});
      if (dest == 2) expP.push_back({i == 0, i == len - 1, frm[i]});
    end
    for (int i = 0; i < len; i++) begin
      if (seed[0] && i == 8) begin
        @(negedge clk);
        rxValid = '0; rxSof = '0; rxEof = '0;
      end
      @(negedge clk);
      rxValid = '0; rxSof = '0; rxEof = '0;
      rxValid[port-1] = 1'b1;
      rxSof[port-1]   = (i == 0);
      rxEof[port-1]   = (i == len - 1);
      rxData[(port-1)*8 +: 8] = frm[i];
      cfgPortWr  = (i == wrAt);
      cfgPortNum = 3'(wrPort);
    end
    @(negedge clk);
    rxValid = '0; rxSof = '0; rxEof = '0; cfgPortWr = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic checkStreams(input string req);
    bit ok;
    ok = (gotM.size() == expM.size());
    for (int i = 0; ok && i < expM.size(); i++) ok = (gotM[i] == expM[i]);
    report(ok, req, "management stream bytes", gotM.size(), expM.size());
    ok = (gotP.size() == expP.size());
    for (int i = 0; ok && i < expP.size(); i++) ok = (gotP[i] == expP[i]);
    report(ok, req, "pass-through stream bytes", gotP.size(), expP.size());
    gotM.delete(); gotP.delete(); expM.delete(); expP.delete();
  endtask

  initial begin
    doReset(1'b1);
    // R1: quiet outputs after reset
    begin
      bit quiet;
      quiet = 1'b1;
      repeat (5) begin
        @(negedge clk);
        if (mgmtValid || passValid || dropPulse) quiet = 1'b0;
      end
      report(quiet, "R1", "outputs idle after reset", int'(quiet), 1);
    end
    // R1, R4: port 7 is the default management port
    sendFrame(7, 20, 0, 2, 1, -1, 0);
    checkStreams("R1");
    pulseDone();

    // R3, R5: each checked header field corrupted in turn
    for (int kind = 1; kind <= 10; kind++) begin
      sendFrame(7, 24, kind, kind * 2, 2, -1, 0);
      checkStreams("R3");
    end
    // R3: priority, mode and sequence values do not matter
    for (int s = 0; s < 16; s++) begin
      sendFrame(7, 18, 0, s * 16 + 15 - s, 1, -1, 0);
      checkStreams("R3");
      pulseDone();
    end

    // R5: short frames always pass
    for (int len = 1; len < 16; len++) begin
      sendFrame(7, len, 0, len, 2, -1, 0);
      checkStreams("R5");
    end
    // R4: qualifying frames of several lengths
    for (int len = 16; len <= 64; len += 6) begin
      sendFrame(7, len, 0, len, 1, -1, 0);
      checkStreams("R4");
      pulseDone();
    end

    // R6, R8, R7: busy behaviour
    dropCnt = 0;
    sendFrame(7, 30, 0, 4, 1, -1, 0);
    checkStreams("R4");
    sendFrame(7, 30, 0, 6, 0, -1, 0);
    checkStreams("R6");
    report(dropCnt == 1, "R6", "drop strobe count", dropCnt, 1);
    sendFrame(7, 28, 10, 8, 2, -1, 0);
    checkStreams("R8");
    sendFrame(7, 22, 0, 3, 0, -1, 0);
    checkStreams("R6");
    report(dropCnt == 2, "R6", "drop strobe count", dropCnt, 2);
    pulseDone();
    sendFrame(7, 26, 0, 10, 1, -1, 0);
    checkStreams("R7");
    pulseDone();
    report(dropCnt == 2, "R7", "no drop after response done", dropCnt, 2);

    // R9, R10: every selected port against every source port
    for (int sel = 1; sel <= NPORTS; sel++) begin
      writePort(sel);
      for (int src = 1; src <= NPORTS; src++) begin
        sendFrame(src, 20, 0, sel + src, (src == sel) ? 1 : 0, -1, 0);
        checkStreams((src == sel) ? "R10" : "R9");
        if (src == sel) pulseDone();
      end
    end
    // R10: writing 0 is ignored; port 7 stays selected
    writePort(0);
    sendFrame(7, 20, 0, 12, 1, -1, 0);
    checkStreams("R10");
    pulseDone();
    // R10: a write during a frame waits for the frame to end
    sendFrame(7, 24, 0, 14, 1, 5, 2);
    checkStreams("R10");
    pulseDone();
    sendFrame(2, 24, 0, 16, 1, -1, 0);
    checkStreams("R10");
    pulseDone();

    // R2: enable strapped low at reset, raised later
    doReset(1'b0);
    strapEn = 1'b1;
    sendFrame(7, 20, 0, 2, 2, -1, 0);
    checkStreams("R2");
    sendFrame(7, 20, 0, 5, 2, -1, 0);
    checkStreams("R2");
    report(dropCnt == 0, "R2", "no drop while disabled", dropCnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule